// File: doc/BRIEF.md
# PHY Start-up Sequencer

This block runs the power-up handshake that a storage-card interface PHY needs before its datapath can carry traffic. Software programs one timing register through a plain write/read port. The register holds four 4-bit phase lengths, two mode bits and a start bit. Setting the start bit launches a fixed series of phases. First a synchronization-enable strobe is held toward the PHY datapath. A quiet gap follows, then a synchronization-reset strobe is held. A settle wait comes next, and a fixed tail of eight extra cycles closes the run. The total run length is the sum of the four fields plus eight cycles.

The start bit reads back as 1 for the whole run and clears itself at the end. A one-cycle done pulse marks the moment it clears. Software must start the sequence again after the card clock changes frequency or is stopped and restarted, and after the mode or function settings change. The slow-mode bit (PHY bypass) and the SDIO-mode bit are held here as plain read/write bits for the rest of the PHY logic.

Top module: `phyInitSeq`

## Requirements
- R1: After reset, the register reads 0x0000_0000, both strobes are low, busy is low and done is low.
- R2: A write with bit 31 = 0 while idle stores the phase fields: sync-reset length in bits [3:0], gap length in [7:4], sync-enable length in [11:8] and settle length in [15:12]. They read back at the same positions and no sequence starts.
- R3: A write with bit 31 = 1 while idle starts the sequence with the written fields. From the next cycle, bit 31 of the read value and the busy output are 1 for exactly (sum of the four fields + 8) cycles.
- R4: syncEn is high during the first N cycles of the run, where N is bits [11:8], and low at all other times.
- R5: After the gap (bits [7:4] cycles), syncRst is high for exactly bits [3:0] cycles. syncEn and syncRst are never high together.
- R6: After syncRst, busy stays high for the settle length (bits [15:12]) plus 8 tail cycles, with both strobes low.
- R7: A zero field gives a phase of zero length. With all fields zero, busy is high for exactly 8 cycles and neither strobe is raised.
- R8: While busy, writes do not change the phase fields and a start request neither restarts nor extends the run.
- R9: done is high for exactly one cycle: the first cycle in which bit 31 reads 0 after a run. It is low at all other times.
- R10: Bit 29 (slow mode) and bit 28 (SDIO mode) are plain read/write bits that accept writes at any time, including while busy. Bits 30 and [27:16] always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 32 | Register write value |
| rdData | output | 32 | Register read value; bit 31 is the busy flag |
| syncEn | output | 1 | Synchronization-enable strobe toward the PHY datapath |
| syncRst | output | 1 | Synchronization-reset strobe toward the PHY datapath |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the sequence ends |

## Verification
Some rules are checked by the assertions on every cycle:
- the two strobes never overlap, and neither is raised outside a run;
- done is a single-cycle pulse that matches the fall of busy;
- the phase fields stay stable for as long as busy is high;
- the last busy cycle always lies in the strobe-free tail.

Other behaviour can only be shown by the bench's scenarios. These are the exact length of each phase for chosen field values, including zero and maximum fields, the end-to-end run length, and the field and mode readback. They also cover the effect of a start-plus-data write made in the middle of a run: the fields and the run are unchanged, while the mode bits are updated.

// File: rtl/phyInitPkg.sv
package phyInitPkg;
  localparam int NUM_PH = 5;

  typedef enum logic [2:0] {
    PH_EN     = 3'd0,
    PH_GAP    = 3'd1,
    PH_RST    = 3'd2,
    PH_SETTLE = 3'd3,
    PH_TAIL   = 3'd4
  } phase_t;

  typedef struct packed {
    logic   load;
    logic   dec;
    phase_t sel;
  } ctrl_s;
endpackage

// File: rtl/phyInitDp.sv
module phyInitDp
  import phyInitPkg::*;
#(
  parameter int FIELD_W     = 4,
  parameter int TAIL_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [31:0]       wrData,
  input  logic              busy,
  input  ctrl_s             ctrl,
  output logic [NUM_PH-1:0] lenNz,
  output logic              cntZero,
  output logic [31:0]       rdData
);
  localparam int NUM_FIELDS = 4;
  localparam int FIELD_MAX  = (1 << FIELD_W) - 1;
  localparam int MAX_LEN    = (FIELD_MAX > TAIL_CYCLES) ? FIELD_MAX : TAIL_CYCLES;
  localparam int CNT_W      = $clog2(MAX_LEN + 1);
  localparam int BIT_SLOW   = 29;
  localparam int BIT_SDIO   = 28;
  localparam int BIT_BUSY   = 31;

  logic [FIELD_W-1:0] fieldQ   [NUM_FIELDS];
  logic [FIELD_W-1:0] fieldSrc [NUM_FIELDS];
  logic               slowQ, sdioQ;
  logic [CNT_W-1:0]   cntQ;
  logic               idleWr;

  assign idleWr = wrEn && !busy;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_FIELDS; gi++) begin : g_field
      assign fieldSrc[gi] = idleWr ? wrData[gi*FIELD_W +: FIELD_W] : fieldQ[gi];
      always_ff @(posedge clk) begin
        if (!rstN) fieldQ[gi] <= '0;
        else if (idleWr) fieldQ[gi] <= wrData[gi*FIELD_W +: FIELD_W];
      end
    end
  endgenerate

  function automatic logic [CNT_W-1:0] phaseLen(input phase_t ph);
    case (ph)
      PH_EN:     phaseLen = CNT_W'(fieldSrc[2]);
      PH_GAP:    phaseLen = CNT_W'(fieldSrc[1]);
      PH_RST:    phaseLen = CNT_W'(fieldSrc[0]);
      PH_SETTLE: phaseLen = CNT_W'(fieldSrc[3]);
      default:   phaseLen = CNT_W'(TAIL_CYCLES);
    endcase
  endfunction

  always_comb begin
    for (int p = 0; p < NUM_PH; p++) lenNz[p] = (phaseLen(phase_t'(p)) != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slowQ <= 1'b0;
      sdioQ <= 1'b0;
    end else if (wrEn) begin
      slowQ <= wrData[BIT_SLOW];
      sdioQ <= wrData[BIT_SDIO];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) cntQ <= '0;
    else if (ctrl.load) cntQ <= phaseLen(ctrl.sel) - 1'b1;
    else if (ctrl.dec) cntQ <= cntQ - 1'b1;
  end

  assign cntZero = (cntQ == '0);

  always_comb begin
    rdData = '0;
    for (int f = 0; f < NUM_FIELDS; f++) rdData[f*FIELD_W +: FIELD_W] = fieldQ[f];
    rdData[BIT_SLOW] = slowQ;
    rdData[BIT_SDIO] = sdioQ;
    rdData[BIT_BUSY] = busy;
  end
endmodule

// File: rtl/phyInitCtrl.sv
module phyInitCtrl
  import phyInitPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              startBit,
  input  logic [NUM_PH-1:0] lenNz,
  input  logic              cntZero,
  output ctrl_s             ctrl,
  output logic              busy,
  output logic              done,
  output logic              syncEn,
  output logic              syncRst
);
  logic   busyQ, doneQ;
  phase_t phaseQ, nextPh;
  logic   startReq, phaseEnd, lastPh;
  int     fromIdx;

  assign startReq = wrEn && startBit && !busyQ;
  assign phaseEnd = busyQ && cntZero;
  assign lastPh   = (phaseQ == PH_TAIL);
  assign fromIdx  = startReq ? 0 : (int'(phaseQ) + 1);

  always_comb begin
    nextPh = PH_TAIL;
    for (int p = NUM_PH - 1; p >= 0; p--) begin
      if (p >= fromIdx && lenNz[p]) nextPh = phase_t'(p);
    end
  end

  always_comb begin
    ctrl.load = startReq || (phaseEnd && !lastPh);
    ctrl.dec  = busyQ && !cntZero;
    ctrl.sel  = nextPh;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      doneQ  <= 1'b0;
      phaseQ <= PH_EN;
    end else begin
      doneQ <= 1'b0;
      if (startReq) begin
        busyQ  <= 1'b1;
        phaseQ <= nextPh;
      end else if (phaseEnd) begin
        if (lastPh) begin
          busyQ <= 1'b0;
          doneQ <= 1'b1;
        end else begin
          phaseQ <= nextPh;
        end
      end
    end
  end

  assign busy    = busyQ;
  assign done    = doneQ;
  assign syncEn  = busyQ && (phaseQ == PH_EN);
  assign syncRst = busyQ && (phaseQ == PH_RST);
endmodule

// File: rtl/phyInitSeq.sv
module phyInitSeq
  import phyInitPkg::*;
#(
  parameter int FIELD_W     = 4,
  parameter int TAIL_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        syncEn,
  output logic        syncRst,
  output logic        busy,
  output logic        done
);
  ctrl_s             ctrl;
  logic [NUM_PH-1:0] lenNz;
  logic              cntZero;

  phyInitCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .startBit(wrData[31]),
    .lenNz(lenNz), .cntZero(cntZero), .ctrl(ctrl), .busy(busy),
    .done(done), .syncEn(syncEn), .syncRst(syncRst)
  );

  phyInitDp #(.FIELD_W(FIELD_W), .TAIL_CYCLES(TAIL_CYCLES)) dp_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .busy(busy),
    .ctrl(ctrl), .lenNz(lenNz), .cntZero(cntZero), .rdData(rdData)
  );
endmodule

// File: rtl/phyInitSeqChk.sv
module phyInitSeqChk (
  input logic        clk,
  input logic        rstN,
  input logic [31:0] rdData,
  input logic        syncEn,
  input logic        syncRst,
  input logic        busy,
  input logic        done
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(syncEn && syncRst)); // R5

  AST_STROBE_IN_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (syncEn || syncRst) |-> busy); // R3

  AST_BUSY_BIT: assert property (@(posedge clk) disable iff (!rstN)
    rdData[31] == busy); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9

  AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done); // R9

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R9

  AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(rdData[15:0])); // R8

  AST_TAIL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (!$past(syncEn) && !$past(syncRst))); // R6
endmodule

bind phyInitSeq phyInitSeqChk chk_i (
  .clk(clk), .rstN(rstN), .rdData(rdData), .syncEn(syncEn),
  .syncRst(syncRst), .busy(busy), .done(done)
);

// File: tb/phyInitSeq_tb_top.sv
`timescale 1ns/1ps
module phyInitSeq_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        syncEn, syncRst, busy, done;

  int checks = 0;
  int errors = 0;

  typedef struct packed {
    logic b;
    logic e;
    logic r;
    logic d;
  } exp_t;
  exp_t expQ[$];
  int   cycIdx = 0;

  always #10 clk = ~clk;

  phyInitSeq dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .syncEn(syncEn), .syncRst(syncRst), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // monitor: pops one expected item per cycle
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      exp_t x;
      x = expQ.pop_front();
      check(busy == x.b && rdData[31] == x.b, $sformatf("R3 busy cyc %0d", cycIdx),
            {30'd0, rdData[31], busy}, {30'd0, x.b, x.b});
      check(syncEn == x.e, $sformatf("R4 syncEn cyc %0d", cycIdx),
            {31'd0, syncEn}, {31'd0, x.e});
      check(syncRst == x.r, $sformatf("R5 syncRst cyc %0d", cycIdx),
            {31'd0, syncRst}, {31'd0, x.r});
      check(done == x.d, $sformatf("R9 done cyc %0d", cycIdx),
            {31'd0, done}, {31'd0, x.d});
      cycIdx++;
    end
  end

  task automatic regWrite(input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = d;
    @(posedge clk);
    #1;
    wrEn = 1'b0;
  endtask

  // driver: start a run and push the expected per-cycle stream
  task automatic runSeq(input logic [31:0] d, input int intrudeAt,
                        input logic [31:0] junk);
    int e, g, r, s, total;
    e = int'(d[11:8]);
    g = int'(d[7:4]);
    r = int'(d[3:0]);
    s = int'(d[15:12]);
    total = e + g + r + s + 8;
    regWrite(d);
    cycIdx = 0;
    for (int i = 0; i <= total + 1; i++) begin
      exp_t x;
      x.b = (i < total);
      x.e = (i < e);
      x.r = (i >= e + g) && (i < e + g + r);
      x.d = (i == total);
      expQ.push_back(x);
    end
    if (intrudeAt >= 0) begin
      repeat (intrudeAt) @(negedge clk);
      wrEn = 1'b1;
      wrData = junk;
      @(posedge clk);
      #1;
      wrEn = 1'b0;
    end
    wait (expQ.size() == 0);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(rdData == 32'h0, "R1 rdData", rdData, 32'h0);
    check({syncEn, syncRst, busy, done} == 4'b0, "R1 outputs",
          {28'd0, syncEn, syncRst, busy, done}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 / R10: configuration write without start, spare bits read 0
    regWrite(32'h7FFF_1234);
    repeat (3) @(negedge clk);
    check(rdData == 32'h3000_1234, "R2 R10 readback", rdData, 32'h3000_1234);
    check(!busy && !syncEn && !syncRst, "R2 no start", {31'd0, busy}, 32'h0);
    regWrite(32'h1000_0000);
    @(negedge clk);
    check(rdData == 32'h1000_0000, "R10 sdio only", rdData, 32'h1000_0000);

    // R3 R4 R5 R6: mixed fields, E=3 G=2 R=4 S=5
    runSeq(32'h8000_5324, -1, 32'h0);
    check(rdData == 32'h0000_5324, "R3 bit31 cleared", rdData, 32'h0000_5324);
    // R7: all zero fields
    runSeq(32'h8000_0000, -1, 32'h0);
    // R7: zero sync-enable phase, E=0 G=2 R=1 S=1
    runSeq(32'h8000_1021, -1, 32'h0);
    // R6: maximum fields
    runSeq(32'h8000_FFFF, -1, 32'h0);
    // R8 / R10: start+data write mid-run is ignored except mode bits
    runSeq(32'h8000_2212, 4, 32'hB000_FFFF);
    check(rdData == 32'h3000_2212, "R8 R10 after intrusion", rdData, 32'h3000_2212);
    repeat (4) @(negedge clk);
    check(!busy && !done, "R8 no restart", {30'd0, busy, done}, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule